// File: doc/BRIEF.md
# Track Defect Record Parser

This block reads the deserialized byte stream of a track. It looks only at the stretch that starts at the index pulse and ends at the first sector mark. Inside that stretch it hunts past the zero gap for a sync byte. It then captures a short record that lists up to three flawed byte positions on the track, each as a 16-bit address.

When the first sector mark arrives, the block checks the record's 16-bit checksum and publishes the result. A good record gives the three addresses, a present flag for each nonzero address, and a checksum-good flag. A bad, truncated or missing record clears everything.

A second stage compares a running byte position, supplied by the data path, against the published list. It raises a one-cycle hit so that the controller can skip the flawed byte.

Top module: `defect_map_parser`

## Requirements
- R1: While reset is high and on the first cycle after it, `dfct_addr`, `dfct_present`, `sum_ok` and `hit` are all zero.
- R2: A byte (`byte_vld` high) is considered only if a window is open and `sector_mark` does not rise in the same cycle. The window opens on the clock after `index_pulse` goes from low to high, and closes on the clock at which `sector_mark` goes from low to high. Bytes outside the window, including a 0xFB, have no effect.
- R3: Inside the window, every byte before the first 0xFB is skipped, whether it is zero or not.
- R4: The eight bytes after the sync byte are, in order: address 0 high, address 0 low, address 1 high, address 1 low, address 2 high, address 2 low, checksum high, checksum low. Bytes after the eighth are ignored.
- R5: When `sector_mark` rises with the window open, eight bytes have been captured, and the checksum equals the 16-bit sum (mod 65536) of the six address bytes, then on the next clock `sum_ok` is 1. In that case `dfct_addr[16*i+15:16*i]` holds address i, and `dfct_present[i]` is 1 exactly when address i is nonzero.
- R6: When `sector_mark` rises with the window open and no sync byte was found, fewer than eight bytes followed the sync, or the checksum does not match, then on the next clock `sum_ok`, `dfct_present` and `dfct_addr` are all zero.
- R7: The published outputs change only on the clock after a `sector_mark` rise that closes an open window. A sector mark with no open window leaves them unchanged.
- R8: An `index_pulse` rise while the window is open discards any partial record, and the hunt for the sync byte starts again.
- R9: `hit` is 1 on the clock after a cycle in which `pos_vld` is high, `sum_ok` is 1 and `pos` equals a nonzero published address; otherwise `hit` is 0.
- R10: A zero address never matches, so `pos` = 0 never gives a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_vld | input | 1 | Strobe for `byte_dat` |
| byte_dat | input | 8 | Deserialized track byte |
| index_pulse | input | 1 | Index pulse level, active high |
| sector_mark | input | 1 | Sector mark level, active high |
| pos_vld | input | 1 | Strobe for `pos` |
| pos | input | 16 | Running byte position on the track |
| dfct_addr | output | 48 | Published defect addresses, entry i in bits 16*i+15:16*i |
| dfct_present | output | 3 | Entry i holds a nonzero address |
| sum_ok | output | 1 | Last record passed its checksum |
| hit | output | 1 | Position matched a listed defect one cycle earlier |

## Verification
The edge detectors are registered, so the window opens one clock after the cycle in which the index is first seen high. A byte therefore counts only from the following cycle. The list is published exactly one clock after the cycle in which the sector mark is first seen high, and `hit` trails its `pos_vld` cycle by one clock. The bench drives inputs on falling edges. A behavioural model steps on each rising edge using the same one-register delays, and every output is compared on the next falling edge. Each published value and each hit is therefore checked in precisely the cycle it is due, and also in every cycle in which it must hold.

// File: rtl/dmp_pkg.sv
package dmp_pkg;
  typedef enum logic [1:0] {
    ST_HUNT,
    ST_GRAB,
    ST_FULL
  } dmp_state_e;

  localparam int CK_BYTES = 2;
endpackage

// File: rtl/dmp_rise.sv
module dmp_rise (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/dmp_record.sv
module dmp_record
  import dmp_pkg::*;
#(
  parameter int        N_DEF = 3,
  parameter int        AW    = 16,
  parameter logic [7:0] SYNC = 8'hFB
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                idx_rise,
  input  logic                sm_rise,
  input  logic                byte_vld,
  input  logic [7:0]          byte_dat,
  output logic [N_DEF*AW-1:0] dfct_addr,
  output logic [N_DEF-1:0]    dfct_present,
  output logic                sum_ok
);
  localparam int AB      = AW / 8;
  localparam int ADDR_BY = N_DEF * AB;
  localparam int REC_LEN = ADDR_BY + CK_BYTES;
  localparam int CW      = $clog2(REC_LEN + 1);

  dmp_state_e     st;
  logic           window;
  logic [CW-1:0]  cnt;
  logic [15:0]    sum_acc;
  logic [7:0]     rec_mem [REC_LEN];
  logic [AW-1:0]  rec_word [N_DEF];
  logic [15:0]    ck_word;
  logic           take;
  logic           rec_good;

  assign take = byte_vld & window & ~sm_rise;

  // record storage, no reset so it can map to plain memory
  always_ff @(posedge clk) begin
    if (take && st == ST_GRAB) rec_mem[cnt] <= byte_dat;
  end

  always_comb begin
    for (int i = 0; i < N_DEF; i++) begin
      rec_word[i] = '0;
      for (int j = 0; j < AB; j++)
        rec_word[i] = {rec_word[i][AW-9:0], rec_mem[i*AB + j]};
    end
    ck_word  = {rec_mem[REC_LEN-2], rec_mem[REC_LEN-1]};
    rec_good = (st == ST_FULL) && (ck_word == sum_acc);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      window       <= 1'b0;
      st           <= ST_HUNT;
      cnt          <= '0;
      sum_acc      <= '0;
      dfct_addr    <= '0;
      dfct_present <= '0;
      sum_ok       <= 1'b0;
    end else begin
      if (idx_rise)     window <= 1'b1;
      else if (sm_rise) window <= 1'b0;

      if (idx_rise) begin
        st      <= ST_HUNT;
        cnt     <= '0;
        sum_acc <= '0;
      end else if (take) begin
        case (st)
          ST_HUNT: if (byte_dat == SYNC) st <= ST_GRAB;
          ST_GRAB: begin
            if (cnt < CW'(ADDR_BY)) sum_acc <= sum_acc + 16'(byte_dat);
            if (cnt == CW'(REC_LEN - 1)) st <= ST_FULL;
            cnt <= cnt + 1'b1;
          end
          default: ;
        endcase
      end

      if (sm_rise && window) begin
        sum_ok <= rec_good;
        for (int i = 0; i < N_DEF; i++) begin
          dfct_addr[i*AW +: AW] <= rec_good ? rec_word[i] : '0;
          dfct_present[i]       <= rec_good && (rec_word[i] != '0);
        end
      end
    end
  end
endmodule

// File: rtl/dmp_match.sv
module dmp_match #(
  parameter int N_DEF = 3,
  parameter int AW    = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pos_vld,
  input  logic [AW-1:0]       pos,
  input  logic [N_DEF*AW-1:0] dfct_addr,
  input  logic [N_DEF-1:0]    dfct_present,
  input  logic                sum_ok,
  output logic                hit
);
  logic [N_DEF-1:0] eq;

  for (genvar g = 0; g < N_DEF; g++) begin : g_cmp
    assign eq[g] = dfct_present[g] && (dfct_addr[g*AW +: AW] == pos);
  end

  always_ff @(posedge clk) begin
    if (rst) hit <= 1'b0;
    else     hit <= pos_vld && sum_ok && (|eq);
  end
endmodule

// File: rtl/defect_map_parser.sv
module defect_map_parser #(
  parameter int         N_DEF = 3,
  parameter int         AW    = 16,
  parameter logic [7:0] SYNC  = 8'hFB
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                byte_vld,
  input  logic [7:0]          byte_dat,
  input  logic                index_pulse,
  input  logic                sector_mark,
  input  logic                pos_vld,
  input  logic [AW-1:0]       pos,
  output logic [N_DEF*AW-1:0] dfct_addr,
  output logic [N_DEF-1:0]    dfct_present,
  output logic                sum_ok,
  output logic                hit
);
  logic idx_rise;
  logic sm_rise;

  dmp_rise u_idx (.clk(clk), .rst(rst), .lvl(index_pulse), .rise(idx_rise));
  dmp_rise u_sm  (.clk(clk), .rst(rst), .lvl(sector_mark), .rise(sm_rise));

  dmp_record #(.N_DEF(N_DEF), .AW(AW), .SYNC(SYNC)) u_rec (
    .clk(clk), .rst(rst), .idx_rise(idx_rise), .sm_rise(sm_rise),
    .byte_vld(byte_vld), .byte_dat(byte_dat),
    .dfct_addr(dfct_addr), .dfct_present(dfct_present), .sum_ok(sum_ok)
  );

  dmp_match #(.N_DEF(N_DEF), .AW(AW)) u_match (
    .clk(clk), .rst(rst), .pos_vld(pos_vld), .pos(pos),
    .dfct_addr(dfct_addr), .dfct_present(dfct_present), .sum_ok(sum_ok),
    .hit(hit)
  );
endmodule

// File: rtl/dmp_checker.sv
module dmp_checker #(
  parameter int N_DEF = 3,
  parameter int AW    = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                sm_rise,
  input logic                pos_vld,
  input logic [AW-1:0]       pos,
  input logic [N_DEF*AW-1:0] dfct_addr,
  input logic [N_DEF-1:0]    dfct_present,
  input logic                sum_ok,
  input logic                hit
);
  assert_cleared_when_bad_R6: assert property (@(posedge clk) disable iff (rst)
    !sum_ok |-> (dfct_present == '0 && dfct_addr == '0));

  assert_hold_between_marks_R7: assert property (@(posedge clk) disable iff (rst)
    !sm_rise |=> ($stable(dfct_addr) && $stable(dfct_present) && $stable(sum_ok)));

  assert_hit_needs_probe_R9: assert property (@(posedge clk) disable iff (rst)
    hit |-> ($past(pos_vld) && $past(sum_ok)));

  assert_no_zero_hit_R10: assert property (@(posedge clk) disable iff (rst)
    hit |-> ($past(pos) != '0));

  for (genvar g = 0; g < N_DEF; g++) begin : g_chk
    assert_present_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
      dfct_present[g] |-> (dfct_addr[g*AW +: AW] != '0));
  end
endmodule

bind defect_map_parser dmp_checker #(.N_DEF(N_DEF), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .sm_rise(sm_rise), .pos_vld(pos_vld), .pos(pos),
  .dfct_addr(dfct_addr), .dfct_present(dfct_present), .sum_ok(sum_ok), .hit(hit)
);

// File: tb/tb_defect_map_parser.sv
module tb_defect_map_parser;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_dat = 8'h00;
  logic        index_pulse = 1'b0;
  logic        sector_mark = 1'b0;
  logic        pos_vld = 1'b0;
  logic [15:0] pos = 16'h0;
  logic [47:0] dfct_addr;
  logic [2:0]  dfct_present;
  logic        sum_ok;
  logic        hit;

  int    vectors = 0;
  int    fails = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  defect_map_parser dut (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_dat(byte_dat),
    .index_pulse(index_pulse), .sector_mark(sector_mark),
    .pos_vld(pos_vld), .pos(pos),
    .dfct_addr(dfct_addr), .dfct_present(dfct_present), .sum_ok(sum_ok), .hit(hit)
  );

  // behavioural reference
  bit          m_win, m_hunt, m_iq, m_sq;
  bit [7:0]    m_q[$];
  bit [15:0]   e_a[3];
  bit [2:0]    e_pres;
  bit          e_ok, e_hit;

  always @(posedge clk) begin
    bit ir, sr, nh;
    bit [15:0] s, w;
    if (rst) begin
      m_win = 0; m_hunt = 1; m_q.delete(); m_iq = 0; m_sq = 0;
      e_a = '{default: 16'h0}; e_pres = 0; e_ok = 0; e_hit = 0;
    end else begin
      ir = index_pulse && !m_iq;
      sr = sector_mark && !m_sq;
      m_iq = index_pulse;
      m_sq = sector_mark;
      nh = 0;
      if (pos_vld && e_ok && pos != 0)
        for (int i = 0; i < 3; i++) if (e_a[i] == pos) nh = 1;
      e_hit = nh;
      if (sr && m_win) begin
        e_ok = 0;
        if (m_q.size() == 8) begin
          s = 0;
          for (int i = 0; i < 6; i++) s = s + 16'(m_q[i]);
          e_ok = (s == {m_q[6], m_q[7]});
        end
        for (int i = 0; i < 3; i++) begin
          w = e_ok ? {m_q[2*i], m_q[2*i+1]} : 16'h0;
          e_a[i] = w;
          e_pres[i] = (w != 0);
        end
      end
      if (ir) begin
        m_q.delete(); m_hunt = 1;
      end else if (byte_vld && m_win && !sr) begin
        if (m_hunt) begin
          if (byte_dat == 8'hFB) m_hunt = 0;
        end else if (m_q.size() < 8) m_q.push_back(byte_dat);
      end
      if (ir) m_win = 1;
      else if (sr) m_win = 0;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      vectors++;
      if (sum_ok !== e_ok) begin
        fails++; $display("FAIL %s sum_ok actual=%0b expected=%0b", cur_req, sum_ok, e_ok);
      end
      if (dfct_present !== e_pres) begin
        fails++; $display("FAIL %s present actual=%b expected=%b", cur_req, dfct_present, e_pres);
      end
      if (dfct_addr !== {e_a[2], e_a[1], e_a[0]}) begin
        fails++; $display("FAIL %s addr actual=%h expected=%h", cur_req, dfct_addr, {e_a[2], e_a[1], e_a[0]});
      end
      if (hit !== e_hit) begin
        fails++; $display("FAIL %s hit actual=%0b expected=%0b", cur_req, hit, e_hit);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input logic [7:0] b);
    byte_vld = 1'b1; byte_dat = b;
    @(negedge clk);
    byte_vld = 1'b0;
  endtask

  task automatic idx_pulse();
    index_pulse = 1'b1; cyc(2); index_pulse = 1'b0; cyc(1);
  endtask

  task automatic sm_pulse();
    sector_mark = 1'b1; cyc(2); sector_mark = 1'b0; cyc(2);
  endtask

  task automatic probe(input logic [15:0] p);
    pos_vld = 1'b1; pos = p;
    @(negedge clk);
    pos_vld = 1'b0;
    @(negedge clk);
  endtask

  // gap, sync, record; n_after limits bytes after sync, bad corrupts checksum
  task automatic send_rec(input logic [15:0] a0, a1, a2, input bit bad, input int n_after);
    logic [7:0] r[8];
    logic [15:0] s;
    r[0] = a0[15:8]; r[1] = a0[7:0]; r[2] = a1[15:8];
    r[3] = a1[7:0];  r[4] = a2[15:8]; r[5] = a2[7:0];
    s = 0;
    for (int i = 0; i < 6; i++) s = s + 16'(r[i]);
    if (bad) s = s ^ 16'h0010;
    r[6] = s[15:8]; r[7] = s[7:0];
    for (int i = 0; i < 23; i++) put(8'h00);
    put(8'hFB);
    for (int i = 0; i < n_after && i < 8; i++) put(r[i]);
    if (n_after >= 8) begin put(8'h00); put(8'h00); put(8'hA5); end
  endtask

  initial begin
    cyc(3);
    cur_req = "R1";
    if (sum_ok !== 0 || dfct_present !== 0 || dfct_addr !== 0 || hit !== 0) begin
      fails++; $display("FAIL R1 reset outputs actual=%0b%b%h%0b expected=0", sum_ok, dfct_present, dfct_addr, hit);
    end
    vectors++;
    rst = 1'b0;
    cyc(2);

    cur_req = "R7"; // mark without window
    put(8'hFB); put(8'h12); sm_pulse();

    cur_req = "R5"; // good record
    idx_pulse(); send_rec(16'h0123, 16'h0000, 16'h1F40, 0, 8); sm_pulse();

    cur_req = "R9";
    probe(16'h0123); probe(16'h1F40); probe(16'h0124); probe(16'h1F41);
    cur_req = "R10";
    probe(16'h0000);

    cur_req = "R6"; // bad checksum
    idx_pulse(); send_rec(16'h0123, 16'h0456, 16'h0789, 1, 8); sm_pulse();
    cur_req = "R9";
    probe(16'h0123);

    cur_req = "R3"; // noise before sync, carry-out checksum
    idx_pulse(); put(8'h55); put(8'hFA); put(8'h00);
    send_rec(16'hFFFF, 16'hFEFE, 16'h8001, 0, 8); sm_pulse();
    probe(16'hFEFE); probe(16'h8001);

    cur_req = "R6"; // no sync at all
    idx_pulse(); for (int i = 0; i < 30; i++) put(8'h00); sm_pulse();
    probe(16'hFEFE);

    cur_req = "R6"; // truncated record
    idx_pulse(); send_rec(16'h0A0B, 16'h0C0D, 16'h0E0F, 0, 5); sm_pulse();

    cur_req = "R8"; // restart mid record
    idx_pulse(); put(8'hFB); put(8'h77); put(8'h66); put(8'h55);
    idx_pulse(); send_rec(16'h0200, 16'h0300, 16'h0000, 0, 8); sm_pulse();
    probe(16'h0300); probe(16'h0000);

    cur_req = "R2"; // sync before index, bytes during mark
    put(8'hFB); put(8'h99); idx_pulse();
    for (int i = 0; i < 8; i++) put(8'h11);
    sector_mark = 1'b1; put(8'hFB); put(8'h01); sector_mark = 1'b0; cyc(2);
    put(8'hFB); for (int i = 0; i < 8; i++) put(8'h22);
    sm_pulse();
    probe(16'h0200);

    cur_req = "R4"; // spaced bytes, trailing bytes ignored
    idx_pulse();
    for (int i = 0; i < 23; i++) begin put(8'h00); cyc(1); end
    put(8'hFB); cyc(2); put(8'h00); cyc(1); put(8'h05); put(8'h10); cyc(3);
    put(8'h00); put(8'h00); put(8'h07); put(8'h00); put(8'h1C);
    put(8'hFF); put(8'hFF); put(8'hFF);
    sm_pulse();
    probe(16'h0005); probe(16'h1000); probe(16'h0007);

    cyc(4);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL %s watchdog actual=timeout expected=finished", cur_req);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule